// File: doc/BRIEF.md
# Low-Side Current-Limit Chopper Timer

This block sequences a fixed-off-time current limit for the low-side switches of an H-bridge. A synchronous comparator input, `trip_i`, reports that the low-side current has reached the limit threshold. When the timer is idle and that input is seen, the block raises `limit_active_o` for a fixed number of clock cycles. While that output is high, the bridge logic holds every output stage in high impedance and the load current decays. When the off interval ends, the bridge returns to the state its direction inputs select. A blanking window follows, and during it the comparator is not trusted, because the switching edge disturbs the current sense.

Both intervals are parameters counted in clock cycles. At a 20 MHz clock the defaults give an off time of about 20.5 us and a blanking time of about 16.5 us, which covers chopping rates well beyond 20 kHz. A separate hard-overcurrent input takes priority over everything else. It returns the timer to idle and drops `limit_active_o`, so that the bridge logic's latched fault path alone decides the outputs. The block copies that input to `oc_pass_o`. Chopping itself never signals a fault, so the status flag stays unchanged while the block chops.

Top module: `lsd_chop_timer`

## Requirements
- R1: While `rst_n` is low, `limit_active_o` and `blanking_o` are both low.
- R2: From idle, with `hard_oc_i` low, a high `trip_i` sampled at a rising edge makes `limit_active_o` high from that edge on.
- R3: `limit_active_o` stays high for exactly OFF_CYCLES consecutive cycles, unless `hard_oc_i` cuts the interval short.
- R4: In the cycle after the off interval, `limit_active_o` is low and `blanking_o` is high. `blanking_o` then stays high for exactly BLANK_CYCLES cycles.
- R5: A high `trip_i` sampled in any blanking cycle except the last has no effect. Blanking keeps its full length and the timer goes idle afterwards.
- R6: If `trip_i` is high at the edge that ends the last blanking cycle, `limit_active_o` rises in the very next cycle. A trip held high from idle therefore repeats OFF_CYCLES high cycles, then BLANK_CYCLES blanking cycles, and so on.
- R7: If `trip_i` is low when blanking ends, both outputs go low and stay low until the next trip.
- R8: A high `hard_oc_i` sampled at an edge, in any state, leaves both `limit_active_o` and `blanking_o` low after that edge. They stay low while `hard_oc_i` remains high, whatever `trip_i` does.
- R9: `oc_pass_o` equals `hard_oc_i` in the same cycle, and it stays low throughout chopping while `hard_oc_i` is low.
- R10: `limit_active_o` and `blanking_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trip_i | input | 1 | Synchronous over-limit comparator result |
| hard_oc_i | input | 1 | Synchronous hard-overcurrent detection |
| limit_active_o | output | 1 | High while the bridge must be held in high impedance |
| blanking_o | output | 1 | High while the comparator is being ignored after re-enable |
| oc_pass_o | output | 1 | Hard-overcurrent request forwarded to the bridge fault latch |

## Verification
Each timer result is due one cycle after the edge that samples its cause: state and counter are registered, and the outputs decode the state. `oc_pass_o` is combinational and is due in the same cycle. The bench changes inputs on falling edges and reads outputs on the following falling edge, half a period after the sampling edge. Sweeps then place a trip at every blanking offset and a hard overcurrent at every offset of the off and blanking intervals. Each expectation comes from the offset and the two interval lengths.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_OFF   = 2'd1,
    CH_BLANK = 2'd2
  } chop_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/chop_down_cnt.sv
module chop_down_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // next value and enable
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load_i) begin
      cnt_d  = load_val_i;
      cnt_en = 1'b1;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int          CW         = 4,
  parameter logic [CW-1:0] OFF_LOAD   = '0,
  parameter logic [CW-1:0] BLANK_LOAD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_i,
  input  logic          hard_oc_i,
  input  logic          cnt_zero_i,
  output chop_state_e   state_o,
  output logic          cnt_clr_o,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_load_val_o,
  output logic          cnt_dec_o
);
  chop_state_e state_q;
  chop_state_e state_d;

  // next-state and counter control
  always_comb begin
    state_d        = state_q;
    cnt_clr_o      = 1'b0;
    cnt_load_o     = 1'b0;
    cnt_load_val_o = '0;
    cnt_dec_o      = 1'b0;
    if (hard_oc_i) begin
      state_d   = CH_IDLE;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        CH_IDLE: begin
          if (trip_i) begin
            state_d        = CH_OFF;
            cnt_load_o     = 1'b1;
            cnt_load_val_o = OFF_LOAD;
          end
        end
        CH_OFF: begin
          if (cnt_zero_i) begin
            state_d        = CH_BLANK;
            cnt_load_o     = 1'b1;
            cnt_load_val_o = BLANK_LOAD;
          end else begin
            cnt_dec_o = 1'b1;
          end
        end
        CH_BLANK: begin
          if (cnt_zero_i) begin
            if (trip_i) begin
              state_d        = CH_OFF;
              cnt_load_o     = 1'b1;
              cnt_load_val_o = OFF_LOAD;
            end else begin
              state_d = CH_IDLE;
            end
          end else begin
            cnt_dec_o = 1'b1;
          end
        end
        default: begin
          state_d   = CH_IDLE;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lsd_chop_timer.sv
module lsd_chop_timer
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES   = 410,
  parameter int BLANK_CYCLES = 330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic hard_oc_i,
  output logic limit_active_o,
  output logic blanking_o,
  output logic oc_pass_o
);
  localparam int MAX_LOAD = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES - 1 : BLANK_CYCLES - 1;
  localparam int CW       = cnt_width(MAX_LOAD);
  localparam logic [CW-1:0] OFF_LOAD   = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYCLES - 1);

  chop_state_e   state;
  logic          cnt_zero;
  logic          cnt_clr;
  logic          cnt_load;
  logic [CW-1:0] cnt_load_val;
  logic          cnt_dec;

  chop_seq #(
    .CW         (CW),
    .OFF_LOAD   (OFF_LOAD),
    .BLANK_LOAD (BLANK_LOAD)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .trip_i         (trip_i),
    .hard_oc_i      (hard_oc_i),
    .cnt_zero_i     (cnt_zero),
    .state_o        (state),
    .cnt_clr_o      (cnt_clr),
    .cnt_load_o     (cnt_load),
    .cnt_load_val_o (cnt_load_val),
    .cnt_dec_o      (cnt_dec)
  );

  chop_down_cnt #(
    .CW (CW)
  ) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cnt_clr),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  assign limit_active_o = (state == CH_OFF);
  assign blanking_o     = (state == CH_BLANK);
  assign oc_pass_o      = hard_oc_i;
endmodule

// File: rtl/lsd_chop_timer_chk.sv
module lsd_chop_timer_chk #(
  parameter int OFF_CYCLES   = 410,
  parameter int BLANK_CYCLES = 330
) (
  input logic clk,
  input logic rst_n,
  input logic trip_i,
  input logic hard_oc_i,
  input logic limit_active_o,
  input logic blanking_o
);
  logic [31:0] lim_len;
  logic [31:0] blk_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_len <= '0;
      blk_len <= '0;
    end else begin
      lim_len <= limit_active_o ? lim_len + 1 : '0;
      blk_len <= blanking_o ? blk_len + 1 : '0;
    end
  end

  p_trip_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!limit_active_o && !blanking_o && trip_i && !hard_oc_i) |=> limit_active_o);

  p_off_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(limit_active_o) && !$past(hard_oc_i)) |-> (lim_len == OFF_CYCLES));

  p_off_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    limit_active_o |-> (lim_len < OFF_CYCLES));

  p_off_to_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(limit_active_o) && !$past(hard_oc_i)) |-> blanking_o);

  p_blank_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blanking_o) && !$past(hard_oc_i)) |-> (blk_len == BLANK_CYCLES));

  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blanking_o) && !$past(hard_oc_i) && $past(trip_i)) |-> limit_active_o);

  p_oc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hard_oc_i |=> (!limit_active_o && !blanking_o));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({limit_active_o, blanking_o}));
endmodule

bind lsd_chop_timer lsd_chop_timer_chk #(
  .OFF_CYCLES   (OFF_CYCLES),
  .BLANK_CYCLES (BLANK_CYCLES)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trip_i         (trip_i),
  .hard_oc_i      (hard_oc_i),
  .limit_active_o (limit_active_o),
  .blanking_o     (blanking_o)
);

// File: tb/test_lsd_chop_timer.sv
module test_lsd_chop_timer;
  localparam int TCLK  = 10;
  localparam int OFF   = 5;
  localparam int BLANK = 3;

  logic clk;
  logic rst_n;
  logic trip_i;
  logic hard_oc_i;
  logic limit_active_o;
  logic blanking_o;
  logic oc_pass_o;

  int n_chk;
  int n_bad;
  bit done;

  lsd_chop_timer #(
    .OFF_CYCLES   (OFF),
    .BLANK_CYCLES (BLANK)
  ) i_lsd_chop_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .trip_i         (trip_i),
    .hard_oc_i      (hard_oc_i),
    .limit_active_o (limit_active_o),
    .blanking_o     (blanking_o),
    .oc_pass_o      (oc_pass_o)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one-cycle trip from idle; returns at the first off cycle
  task automatic pulse_trip();
    @(negedge clk) trip_i = 1'b1;
    @(negedge clk) trip_i = 1'b0;
    chk(limit_active_o, 1, "R2 limit rises after trip");
  endtask

  task automatic drain();
    trip_i = 1'b0;
    repeat (OFF + BLANK + 2) @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R7 idle after drain");
  endtask

  // full single chop, lengths measured
  task automatic measure_chop();
    int n;
    int m;
    pulse_trip();
    n = 0;
    while (limit_active_o && n < 100) begin
      chk(oc_pass_o, 0, "R9 no fault while off");
      chk(blanking_o, 0, "R10 exclusive");
      n++;
      @(negedge clk);
    end
    chk(n, OFF, "R3 off length");
    chk(blanking_o, 1, "R4 blanking follows off");
    m = 0;
    while (blanking_o && m < 100) begin
      chk(oc_pass_o, 0, "R9 no fault while blanking");
      m++;
      @(negedge clk);
    end
    chk(m, BLANK, "R4 blanking length");
    chk({limit_active_o, blanking_o}, 0, "R7 idle after blanking");
    repeat (3) @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R7 stays idle");
  endtask

  // trip placed at blanking offset d
  task automatic blank_probe(input int d);
    pulse_trip();
    repeat (OFF) @(negedge clk);
    for (int k = 0; k < BLANK; k++) begin
      chk(blanking_o, 1, "R5 blanking holds");
      trip_i = (k == d);
      @(negedge clk);
    end
    trip_i = 1'b0;
    if (d == BLANK - 1) chk(limit_active_o, 1, "R6 rearm at last blanking cycle");
    else                chk(limit_active_o, 0, "R5 trip ignored in blanking");
    chk(blanking_o, 0, "R5 blanking ended");
    drain();
  endtask

  // hard overcurrent at offset e from first off cycle
  task automatic oc_probe(input int e);
    pulse_trip();
    repeat (e) @(negedge clk);
    hard_oc_i = 1'b1;
    trip_i    = 1'b1;
    #1 chk(oc_pass_o, 1, "R9 fault passes through");
    @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R8 override clears");
    repeat (3) @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R8 held idle under fault");
    hard_oc_i = 1'b0;
    trip_i    = 1'b0;
    #1 chk(oc_pass_o, 0, "R9 fault released");
    @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R8 idle after release");
  endtask

  initial begin
    #(TCLK * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    trip_i = 1'b1;
    hard_oc_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R1 reset state");
    trip_i = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R1 idle after reset");

    measure_chop();
    measure_chop();

    for (int d = 0; d < BLANK; d++) blank_probe(d);

    // trip held high: repeating chop pattern
    @(negedge clk) trip_i = 1'b1;
    for (int rep = 0; rep < 2; rep++) begin
      @(negedge clk);
      for (int k = 0; k < OFF; k++) begin
        chk(limit_active_o, 1, "R6 held trip off phase");
        if (k < OFF - 1) @(negedge clk);
      end
      for (int k = 0; k < BLANK; k++) begin
        @(negedge clk);
        chk(blanking_o, 1, "R6 held trip blank phase");
      end
    end
    drain();

    for (int e = 0; e < OFF + BLANK; e++) oc_probe(e);

    // fault from idle with trip high
    @(negedge clk) begin hard_oc_i = 1'b1; trip_i = 1'b1; end
    @(negedge clk);
    chk({limit_active_o, blanking_o}, 0, "R8 fault blocks trip from idle");
    hard_oc_i = 1'b0;
    @(negedge clk) trip_i = 1'b0;
    chk(limit_active_o, 1, "R2 trip after fault release");
    drain();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule